// File: doc/BRIEF.md
# Framed Rate-1/2 Convolutional Encoder with Pair Repetition

This block turns a serial user bitstream into a coded bitstream for a single-carrier transmit chain. A message opens when the request-to-send level rises. User bits then flow in through a valid/ready handshake for as long as the level stays high. When the level falls, the block stops taking user bits. It appends a constant 32-bit end-of-message word and then a run of zero bits that empties the coder. If an interleaver follows, extra zero bits are added until the interleaver block that holds the last coder-flush bit is complete.

Every framed bit passes through a rate 1/2, constraint length 7 convolutional encoder. Depending on the rate-select code, each coded pair is sent once, sent two or four times as a whole pair, or the encoder is bypassed and the bit is sent uncoded. The output is a single-bit stream with valid/ready. A one-cycle `done` pulse marks the end of each message.

The sequencer has five states. SEQ_IDLE goes to SEQ_DATA when `rts` is high, and this transition clears the coder history and the block position. SEQ_DATA goes to SEQ_EOM when `rts` is low. SEQ_EOM goes to SEQ_FLUSH when its 32nd bit enters the coder. SEQ_FLUSH goes to SEQ_DRAIN when the bit that completes both the coder flush and the interleaver block enters the coder. SEQ_DRAIN goes to SEQ_IDLE on the handshake of the final output bit.

Top module: `fec_frame_encoder`

## Requirements
- R1: While reset is asserted, and in idle with `rts` low, `out_valid`, `in_ready` and `done` are all 0.
- R2: `in_ready` is high only in the data state while `rts` is high. Once `rts` is low, no further user bit is accepted, and exactly the bits handshaken while `rts` was high are coded.
- R3: Right after the last user bit, the 32 bits of 0x4B65A5B2 enter the coder, most significant bit first (the first eight are 0,1,0,0,1,0,1,1).
- R4: With `blk_bits` = 0, exactly 144 zero bits follow the end-of-message word.
- R5: With `blk_bits` nonzero (a multiple of the coded bits per input bit), the smallest number of zero bits, at least 144, is sent such that the total count of coded output bits in the message is a multiple of `blk_bits`.
- R6: The code uses generators 133 (T1) and 171 (T2) octal. Generator bit 6 multiplies the newest bit and bit 0 the bit that entered six bits earlier. T1 is emitted before T2, and the history is all zero at the start of every message.
- R7: Rate code 4 emits each coded pair 2 times and rate code 5 emits it 4 times, as whole pairs in the order T1,T2,T1,T2,...
- R8: Rate code 0 bypasses the coder: each framed bit is emitted once, unchanged.
- R9: Rate codes 1, 2, 3, 6 and 7 emit each coded pair once.
- R10: `done` is high for exactly one cycle, in the cycle after the handshake of the final output bit, and `out_valid` is then 0.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 3 | Rate code (0 uncoded, 4 pairs x2, 5 pairs x4, others pairs x1); held for the whole message |
| blk_bits | input | BLK_W | Interleaver block size in coded bits, 0 when no interleaver; held for the whole message |
| rts | input | 1 | Request-to-send level that opens and closes the data part |
| in_valid | input | 1 | User bit valid |
| in_bit | input | 1 | User bit |
| in_ready | output | 1 | Block takes the user bit this cycle |
| out_valid | output | 1 | Coded bit valid |
| out_ready | input | 1 | Downstream takes the coded bit |
| out_bit | output | 1 | Coded bit |
| done | output | 1 | One-cycle end-of-message pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit block size, 144 flush bits and constraint length 7. It sweeps all eight rate codes against block sizes of 0, 40 and 48 and message lengths of 0, 3 and 19 user bits. This combination reaches the empty message, the unpadded flush, and paddings that close on different pair and repetition boundaries. A pseudo-random `out_ready` pattern stalls the output on every kind of bit, including the last bit of a repeated pair and the final bit of a message. This exercises the back-to-back load path and the timing of the end pulse.

// File: rtl/fenc_pkg.sv
package fenc_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_DATA,
        SEQ_EOM,
        SEQ_FLUSH,
        SEQ_DRAIN
    } seq_state_t;

    localparam int RATE_W = 3;
    localparam int NC_W   = 4;

    localparam logic [RATE_W-1:0] RATE_RAW  = 3'd0;
    localparam logic [RATE_W-1:0] RATE_REP2 = 3'd4;
    localparam logic [RATE_W-1:0] RATE_REP4 = 3'd5;

    // coded output bits produced for one bit entering the coder
    function automatic logic [NC_W-1:0] coded_per_bit(input logic [RATE_W-1:0] r);
        logic [NC_W-1:0] n;
        unique case (r)
            RATE_RAW:  n = NC_W'(1);
            RATE_REP2: n = NC_W'(4);
            RATE_REP4: n = NC_W'(8);
            default:   n = NC_W'(2);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fenc_conv.sv
module fenc_conv #(
    parameter int                CLEN  = 7,
    parameter logic [CLEN-1:0]   GEN_A = 7'o133,
    parameter logic [CLEN-1:0]   GEN_B = 7'o171
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic din,
    output logic t1,
    output logic t2
);
    localparam int HW = CLEN - 1;

    logic [HW-1:0]   hist_q;
    logic [CLEN-1:0] win;

    // newest bit at the top of the window
    assign win = {din, hist_q};
    assign t1  = ^(win & GEN_A);
    assign t2  = ^(win & GEN_B);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr) begin
            hist_q <= '0;
        end else if (adv) begin
            hist_q <= win[CLEN-1:1];
        end
    end

endmodule

// File: rtl/fenc_repeat.sv
module fenc_repeat #(
    parameter int NC_W    = 4,
    parameter int MAX_OUT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            t1,
    input  logic            t2,
    input  logic            raw,
    input  logic            bypass,
    input  logic [NC_W-1:0] n_out,
    input  logic            out_ready,
    output logic            out_valid,
    output logic            out_bit,
    output logic            can_load,
    output logic            last_fire
);
    localparam int IW = $clog2(MAX_OUT);

    logic            busy_q;
    logic [IW-1:0]   idx_q;
    logic [NC_W-1:0] tot_q;
    logic            a_q;
    logic            b_q;
    logic            byp_q;
    logic            at_last;
    logic            fire;

    assign at_last   = (NC_W'(idx_q) == tot_q - NC_W'(1));
    assign fire      = busy_q & out_ready;
    assign last_fire = fire & at_last;
    assign can_load  = ~busy_q | (out_ready & at_last);
    assign out_valid = busy_q;
    // whole pairs repeat: even slots carry T1, odd slots T2
    assign out_bit   = byp_q ? a_q : (idx_q[0] ? b_q : a_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            tot_q  <= '0;
            a_q    <= 1'b0;
            b_q    <= 1'b0;
            byp_q  <= 1'b0;
        end else if (load) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            tot_q  <= n_out;
            a_q    <= bypass ? raw : t1;
            b_q    <= t2;
            byp_q  <= bypass;
        end else if (last_fire) begin
            busy_q <= 1'b0;
        end else if (fire) begin
            idx_q  <= idx_q + IW'(1);
        end
    end

endmodule

// File: rtl/fenc_seq.sv
module fenc_seq
    import fenc_pkg::*;
#(
    parameter int                  BLK_W     = 16,
    parameter int                  CW        = 4,
    parameter int                  FLUSH_LEN = 144,
    parameter int                  EOM_LEN   = 32,
    parameter logic [EOM_LEN-1:0]  EOM_WORD  = 32'h4B65A5B2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rts,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic [BLK_W-1:0] blk_bits,
    input  logic [CW-1:0]    n_coded,
    input  logic             can_load,
    input  logic             last_fire,
    output logic             in_ready,
    output logic             src_valid,
    output logic             src_bit,
    output logic             take,
    output logic             start,
    output logic             done
);
    localparam int CNT_MAX = (FLUSH_LEN > EOM_LEN) ? FLUSH_LEN : EOM_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int EIDX_W  = $clog2(EOM_LEN);

    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [BLK_W-1:0] pos_q;
    logic [BLK_W-1:0] pos_nx;
    logic [BLK_W:0]   pos_sum;
    logic [EIDX_W-1:0] eidx;
    logic             eom_last;
    logic             coder_flushed;
    logic             blk_closed;
    logic             flush_end;

    // coded-bit position inside the current interleaver block
    assign pos_sum = {1'b0, pos_q} + (BLK_W+1)'(n_coded);
    assign pos_nx  = (blk_bits != '0 && pos_sum >= {1'b0, blk_bits})
                   ? BLK_W'(pos_sum - {1'b0, blk_bits})
                   : pos_sum[BLK_W-1:0];

    assign blk_closed    = (blk_bits == '0) || (pos_nx == '0);
    assign coder_flushed = (cnt_q >= CNT_W'(FLUSH_LEN - 1));
    assign eom_last      = (cnt_q == CNT_W'(EOM_LEN - 1));
    assign flush_end     = coder_flushed && blk_closed;
    assign eidx          = EIDX_W'(EOM_LEN - 1) - cnt_q[EIDX_W-1:0];
    assign take          = src_valid & can_load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:  if (rts) st_d = SEQ_DATA;
            SEQ_DATA:  if (!rts) st_d = SEQ_EOM;
            SEQ_EOM:   if (take && eom_last) st_d = SEQ_FLUSH;
            SEQ_FLUSH: if (take && flush_end) st_d = SEQ_DRAIN;
            SEQ_DRAIN: if (last_fire) st_d = SEQ_IDLE;
            default:   st_d = SEQ_IDLE;
        endcase
    end

    // outputs per state
    always_comb begin
        in_ready  = 1'b0;
        src_valid = 1'b0;
        src_bit   = 1'b0;
        start     = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                start = rts;
            end
            SEQ_DATA: begin
                in_ready  = rts & can_load;
                src_valid = rts & in_valid;
                src_bit   = in_bit;
            end
            SEQ_EOM: begin
                src_valid = 1'b1;
                src_bit   = EOM_WORD[eidx];
            end
            SEQ_FLUSH: begin
                src_valid = 1'b1;
                src_bit   = 1'b0;
            end
            SEQ_DRAIN: begin
                src_valid = 1'b0;
            end
            default: begin
                src_valid = 1'b0;
            end
        endcase
    end

    // framing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pos_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            pos_q <= '0;
        end else if (take) begin
            pos_q <= pos_nx;
            if (st_q == SEQ_EOM && eom_last) begin
                cnt_q <= '0;
            end else if (st_q == SEQ_EOM || (st_q == SEQ_FLUSH && !coder_flushed)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // end-of-message pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (st_q == SEQ_DRAIN) && last_fire;
        end
    end

endmodule

// File: rtl/fec_frame_encoder.sv
module fec_frame_encoder
    import fenc_pkg::*;
#(
    parameter int BLK_W     = 16,
    parameter int FLUSH_LEN = 144,
    parameter int CLEN      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [BLK_W-1:0]  blk_bits,
    input  logic              rts,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_bit,
    output logic              done
);
    localparam int MAX_OUT = 1 << (NC_W - 1);

    logic            src_valid;
    logic            src_bit;
    logic            take;
    logic            start;
    logic            can_load;
    logic            last_fire;
    logic            t1;
    logic            t2;
    logic            bypass;
    logic [NC_W-1:0] n_coded;

    assign bypass  = (rate_sel == RATE_RAW);
    assign n_coded = coded_per_bit(rate_sel);

    fenc_seq #(
        .BLK_W     (BLK_W),
        .CW        (NC_W),
        .FLUSH_LEN (FLUSH_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rts       (rts),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .blk_bits  (blk_bits),
        .n_coded   (n_coded),
        .can_load  (can_load),
        .last_fire (last_fire),
        .in_ready  (in_ready),
        .src_valid (src_valid),
        .src_bit   (src_bit),
        .take      (take),
        .start     (start),
        .done      (done)
    );

    fenc_conv #(
        .CLEN (CLEN)
    ) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .adv   (take),
        .din   (src_bit),
        .t1    (t1),
        .t2    (t2)
    );

    fenc_repeat #(
        .NC_W    (NC_W),
        .MAX_OUT (MAX_OUT)
    ) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .t1        (t1),
        .t2        (t2),
        .raw       (src_bit),
        .bypass    (bypass),
        .n_out     (n_coded),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .can_load  (can_load),
        .last_fire (last_fire)
    );

endmodule

// File: rtl/fec_frame_encoder_chk.sv
module fec_frame_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic rts,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_bit,
    input logic done
);

    a_r11_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

    a_r2_ready_needs_rts: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> rts);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_after_output: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready));

    a_r10_empty_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

endmodule

bind fec_frame_encoder fec_frame_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rts       (rts),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .done      (done)
);

// File: tb/fec_frame_encoder_test.sv
module fec_frame_encoder_test;
    localparam int CLK_P = 10;
    localparam int BLK_W = 16;
    localparam int MSG_LIMIT = 8000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       rate_sel = 3'd0;
    logic [BLK_W-1:0] blk_bits = '0;
    logic             rts = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_bit = 1'b0;
    logic             in_ready;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic             out_bit;
    logic             done;

    int checks = 0;
    int failures = 0;
    logic [15:0] lf = 16'hACE1;
    logic fr   [0:1023];
    logic expv [0:4095];
    logic got  [0:4095];
    logic dat  [0:63];
    localparam logic [31:0] EOM = 32'h4B65A5B2;
    localparam logic [6:0]  GA  = 7'o133;
    localparam logic [6:0]  GB  = 7'o171;

    always #(CLK_P/2) clk = ~clk;

    fec_frame_encoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .blk_bits  (blk_bits),
        .rts       (rts),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit),
        .done      (done)
    );

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic fr_at(input int j);
        return (j < 0) ? 1'b0 : fr[j];
    endfunction

    task automatic run_msg(input int rate, input int blk, input int nd);
        int nc, nf, k, ne, ng, acc, rts_cyc, cyc, done_cnt, bad_done, bad_hold, bad_rts;
        int mism, first_bad;
        logic stall_prev, prev_bit, last_final, a, b;
        string tag;
        nc = (rate == 0) ? 1 : (rate == 4) ? 4 : (rate == 5) ? 8 : 2;
        nf = 144;
        if (blk != 0) begin
            while (((nd + 32 + nf) * nc) % blk != 0) nf++;
        end
        k = nd + 32 + nf;
        for (int i = 0; i < nd; i++) dat[i] = (((i * 13 + rate * 5 + blk + nd) * 37) % 11) > 5;
        for (int i = 0; i < k; i++) begin
            if (i < nd) fr[i] = dat[i];
            else if (i < nd + 32) fr[i] = EOM[31 - (i - nd)];
            else fr[i] = 1'b0;
        end
        ne = 0;
        for (int j = 0; j < k; j++) begin
            if (rate == 0) begin
                expv[ne] = fr[j];
                ne++;
            end else begin
                a = 1'b0;
                b = 1'b0;
                for (int t = 0; t < 7; t++) begin
                    a ^= GA[t] & fr_at(j - (6 - t));
                    b ^= GB[t] & fr_at(j - (6 - t));
                end
                for (int r = 0; r < nc / 2; r++) begin
                    expv[ne] = a;
                    expv[ne + 1] = b;
                    ne += 2;
                end
            end
        end

        rate_sel = 3'(rate);
        blk_bits = BLK_W'(blk);
        ng = 0; acc = 0; rts_cyc = 0; cyc = 0; done_cnt = 0;
        bad_done = 0; bad_hold = 0; bad_rts = 0;
        stall_prev = 1'b0; prev_bit = 1'b0; last_final = 1'b0;
        while (cyc < MSG_LIMIT) begin
            if (stall_prev && !(out_valid && out_bit == prev_bit)) bad_hold++;
            if (done) begin
                done_cnt++;
                if (!last_final) bad_done++;
            end else if (last_final) begin
                bad_done++;
            end
            if (done_cnt > 0) break;
            rts = !(acc == nd && rts_cyc > 0);
            if (rts) rts_cyc++;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            out_ready = (lf[1:0] != 2'b00);
            in_valid = rts && (acc < nd);
            in_bit = in_valid ? dat[acc] : 1'b0;
            #1;
            last_final = 1'b0;
            if (out_valid && out_ready) begin
                if (ng < 4096) got[ng] = out_bit;
                ng++;
                last_final = (ng == ne);
            end
            if (in_valid && in_ready) acc++;
            if (in_ready && !rts) bad_rts++;
            stall_prev = out_valid && !out_ready;
            prev_bit = out_bit;
            @(negedge clk);
            cyc++;
        end
        rts = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        check(cyc < MSG_LIMIT, $sformatf("R10 watchdog rate=%0d blk=%0d nd=%0d actual=hung expected=done", rate, blk, nd));

        mism = 0;
        first_bad = -1;
        for (int i = 0; i < ne && i < ng; i++) begin
            if (got[i] !== expv[i]) begin
                if (first_bad < 0) first_bad = i;
                mism++;
            end
        end
        tag = (rate == 0) ? "R8" : (rate == 4 || rate == 5) ? "R7 R6" : "R9 R6";
        check(mism == 0, $sformatf("%s content rate=%0d blk=%0d nd=%0d first=%0d actual=%0d mismatches expected=0",
                                   tag, rate, blk, nd, first_bad, mism));
        check(ng == ne && (blk == 0 || ng % blk == 0),
              $sformatf("%s length rate=%0d blk=%0d nd=%0d actual=%0d expected=%0d",
                        (blk == 0) ? "R4" : "R5", rate, blk, nd, ng, ne));
        check(done_cnt == 1 && bad_done == 0,
              $sformatf("R10 done rate=%0d blk=%0d nd=%0d actual=%0d/%0d expected=1/0", rate, blk, nd, done_cnt, bad_done));
        check(acc == nd && bad_rts == 0,
              $sformatf("R2 accepted rate=%0d nd=%0d actual=%0d/%0d expected=%0d/0", rate, nd, acc, bad_rts, nd));
        check(bad_hold == 0, $sformatf("R11 hold rate=%0d actual=%0d expected=0", rate, bad_hold));
        if (rate == 0) begin
            mism = 0;
            for (int i = 0; i < 32; i++) begin
                if (nd + i < ng && got[nd + i] !== EOM[31 - i]) mism++;
            end
            check(mism == 0, $sformatf("R3 eom word nd=%0d blk=%0d actual=%0d mismatches expected=0", nd, blk, mism));
        end
        repeat (2) @(negedge clk);
        check(!out_valid && !in_ready && !done,
              $sformatf("R1 idle after message actual=%b%b%b expected=000", out_valid, in_ready, done));
    endtask

    initial begin
        #(CLK_P * 190000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        int blks [3];
        int lens [3];
        blks = '{0, 40, 48};
        lens = '{0, 3, 19};
        repeat (3) @(negedge clk);
        check(!out_valid && !in_ready && !done,
              $sformatf("R1 in reset actual=%b%b%b expected=000", out_valid, in_ready, done));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !in_ready && !done,
              $sformatf("R1 after reset actual=%b%b%b expected=000", out_valid, in_ready, done));
        for (int r = 0; r < 8; r++) begin
            for (int bi = 0; bi < 3; bi++) begin
                for (int li = 0; li < 3; li++) begin
                    run_msg(r, blks[bi], lens[li]);
                end
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule